// File: doc/BRIEF.md
# Command-Style Interrupt Enable Register

This block keeps a bank of interrupt enable bits and turns them, together with an interrupt status vector, into one summary flag and an active-low interrupt pin. Software never overwrites the register as a whole word. Each byte of a 32-bit write carries its own value bit in bit 7 and a seven-bit select map in bits 6:0. Every selected enable in that byte takes the value bit, and the enables that are not selected keep their state. Any group of enables can therefore be set or cleared in one atomic write, with no read-modify-write.

There are 28 enable bits: bits 6:0 of each of the four bytes. The summary flag is the OR, over those 28 positions, of status AND enable. The pin is driven low one clock after the summary flag and a global interrupt enable are both high. Four enables can also be reached through a narrow legacy control view that shares the same storage.

The enables are cleared by an asynchronous hard reset, and also when a configuration load starts or reports a read failure. A soft reset turns on the receive and transmit interrupt enables.

Top module: `irq_enable_cmd_reg`

## Requirements
- R1: On a command write (`wrEn`=1), in each byte b, bit 8b+7 is the value bit and bits 8b+6..8b+0 are the select map. Each enable whose select bit is 1 takes the value bit at the next clock edge. Each enable whose select bit is 0 keeps its state.
- R2: Bits 31, 23, 15 and 7 of `rdData` always read 0, and no write can set them. `rdData` bits 8b+6..8b+0 return the stored enables.
- R3: `irqSummary` is combinational and equals the OR of (`irqStatus` AND enable) over the 28 stored positions. Status bits 31, 23, 15 and 7 have no effect.
- R4: `irqPinN` is registered. After a clock edge it is 0 if `irqSummary` and `globalIrqEn` were both 1 at that edge, and 1 otherwise.
- R5: When `hardRstN` goes low, all enables clear at once, without waiting for a clock edge, and `irqPinN` goes to 1.
- R6: At an edge where `cfgLoadStart` or `cfgLoadFail` is 1, all enables clear. This takes priority over soft reset and over both kinds of write.
- R7: At an edge where `softRst` is 1 and no clear is pending, enable bits 0 (receive) and 1 (transmit) become 1 and all other enables keep their state. Any command or legacy write in that same cycle is dropped.
- R8: `legacyRdData` bits 0, 2, 4 and 8 mirror enable bits 16, 17, 18 and 19; its other bits read 0. A legacy write (`legacyWrEn`=1) loads those four enables from `legacyWrData` bits 0, 2, 4 and 8. The other legacy data bits are ignored.
- R9: When a command write and a legacy write share a cycle, the legacy write decides the four aliased enables and the command write decides all the others.
- R10: In a cycle with no write, clear or soft reset, the enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset strobe |
| cfgLoadStart | input | 1 | Configuration load starting; clears enables |
| cfgLoadFail | input | 1 | Configuration load read failed; clears enables |
| wrEn | input | 1 | Command write strobe |
| wrData | input | 32 | Command word: value bit and select map per byte |
| legacyWrEn | input | 1 | Legacy view write strobe |
| legacyWrData | input | 16 | Legacy view write data |
| irqStatus | input | 32 | Interrupt status vector |
| globalIrqEn | input | 1 | Global interrupt enable |
| rdData | output | 32 | Enable register read value |
| legacyRdData | output | 16 | Legacy view read value |
| irqSummary | output | 1 | Combinational summary interrupt flag |
| irqPinN | output | 1 | Registered interrupt pin, active low |

## Verification
The hardest cases to reach are those where several update sources land on the same edge: a command write with a legacy write, a soft reset over a pending write, and a configuration clear over a soft reset. Because the strobes are plain inputs, the bench drives these collisions directly. It first loads known enables through a table of command words whose results build on one another. It then collides the strobes and checks that the winner alone shaped the register.

// File: rtl/irq_cmd_pkg.sv
`timescale 1ns/1ps
package irq_cmd_pkg;
  localparam int SEL_BITS   = 7;
  localparam int LEG_COUNT  = 4;
  localparam int LEG_BYTE   = 2;
  localparam int LEG_POS [LEG_COUNT] = '{0, 2, 4, 8};
  localparam logic [SEL_BITS-1:0] SOFT_SET_MASK = 7'b0000011;

  typedef struct packed {
    logic clearAll;
    logic softSet;
    logic cmdWr;
    logic legacyWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_cmd_ctrl.sv
`timescale 1ns/1ps
module irq_cmd_ctrl
  import irq_cmd_pkg::*;
(
  input  logic         softRst,
  input  logic         cfgLoadStart,
  input  logic         cfgLoadFail,
  input  logic         wrEn,
  input  logic         legacyWrEn,
  output ctrlStrobes_t strobes
);
  logic clearReq;
  logic writeAllowed;

  // Priority: configuration clear, then soft reset, then writes.
  assign clearReq     = cfgLoadStart | cfgLoadFail;
  assign writeAllowed = ~clearReq & ~softRst;

  always_comb begin
    strobes.clearAll = clearReq;
    strobes.softSet  = softRst & ~clearReq;
    strobes.cmdWr    = wrEn & writeAllowed;
    strobes.legacyWr = legacyWrEn & writeAllowed;
  end
endmodule

// File: rtl/irq_cmd_datapath.sv
`timescale 1ns/1ps
module irq_cmd_datapath
  import irq_cmd_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int LEG_WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   hardRstN,
  input  ctrlStrobes_t           strobes,
  input  logic [8*NUM_BYTES-1:0] wrData,
  input  logic [LEG_WIDTH-1:0]   legacyWrData,
  input  logic [8*NUM_BYTES-1:0] irqStatus,
  input  logic                   globalIrqEn,
  output logic [8*NUM_BYTES-1:0] rdData,
  output logic [LEG_WIDTH-1:0]   legacyRdData,
  output logic                   irqSummary,
  output logic                   irqPinN
);
  logic [NUM_BYTES-1:0][SEL_BITS-1:0] enQ;
  logic [NUM_BYTES-1:0][SEL_BITS-1:0] enD;
  logic [NUM_BYTES-1:0]               byteHit;
  logic                               unusedStatus;
  logic                               unusedLegacy;

  // Value-bit status positions and non-aliased legacy bits carry no function.
  assign unusedStatus = ^irqStatus;
  assign unusedLegacy = ^legacyWrData;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic                valBit;
    logic [SEL_BITS-1:0] selMap;
    logic [SEL_BITS-1:0] afterCmd;
    logic [SEL_BITS-1:0] afterLeg;

    assign valBit = wrData[8*b + SEL_BITS];
    assign selMap = wrData[8*b +: SEL_BITS];

    always_comb begin
      afterCmd = enQ[b];
      if (strobes.cmdWr)
        afterCmd = (enQ[b] & ~selMap) | ({SEL_BITS{valBit}} & selMap);
      afterLeg = afterCmd;
      if (b == LEG_BYTE && strobes.legacyWr)
        for (int k = 0; k < LEG_COUNT; k++)
          afterLeg[k] = legacyWrData[LEG_POS[k]];
      enD[b] = afterLeg;
      if (b == 0 && strobes.softSet)
        enD[b] = enQ[b] | SOFT_SET_MASK;
      if (strobes.clearAll)
        enD[b] = '0;
    end

    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN) enQ[b] <= '0;
      else           enQ[b] <= enD[b];
    end

    assign rdData[8*b +: 8] = {1'b0, enQ[b]};
    assign byteHit[b]       = |(enQ[b] & irqStatus[8*b +: SEL_BITS]);
  end

  always_comb begin
    legacyRdData = '0;
    for (int k = 0; k < LEG_COUNT; k++)
      legacyRdData[LEG_POS[k]] = enQ[LEG_BYTE][k];
  end

  assign irqSummary = |byteHit;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) irqPinN <= 1'b1;
    else           irqPinN <= ~(irqSummary & globalIrqEn);
  end
endmodule

// File: rtl/irq_enable_cmd_reg.sv
`timescale 1ns/1ps
module irq_enable_cmd_reg
  import irq_cmd_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int LEG_WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   hardRstN,
  input  logic                   softRst,
  input  logic                   cfgLoadStart,
  input  logic                   cfgLoadFail,
  input  logic                   wrEn,
  input  logic [8*NUM_BYTES-1:0] wrData,
  input  logic                   legacyWrEn,
  input  logic [LEG_WIDTH-1:0]   legacyWrData,
  input  logic [8*NUM_BYTES-1:0] irqStatus,
  input  logic                   globalIrqEn,
  output logic [8*NUM_BYTES-1:0] rdData,
  output logic [LEG_WIDTH-1:0]   legacyRdData,
  output logic                   irqSummary,
  output logic                   irqPinN
);
  ctrlStrobes_t strobes;

  irq_cmd_ctrl u_ctrl (
    .softRst      (softRst),
    .cfgLoadStart (cfgLoadStart),
    .cfgLoadFail  (cfgLoadFail),
    .wrEn         (wrEn),
    .legacyWrEn   (legacyWrEn),
    .strobes      (strobes)
  );

  irq_cmd_datapath #(
    .NUM_BYTES (NUM_BYTES),
    .LEG_WIDTH (LEG_WIDTH)
  ) u_dp (
    .clk          (clk),
    .hardRstN     (hardRstN),
    .strobes      (strobes),
    .wrData       (wrData),
    .legacyWrData (legacyWrData),
    .irqStatus    (irqStatus),
    .globalIrqEn  (globalIrqEn),
    .rdData       (rdData),
    .legacyRdData (legacyRdData),
    .irqSummary   (irqSummary),
    .irqPinN      (irqPinN)
  );
endmodule

// File: rtl/irq_cmd_chk.sv
`timescale 1ns/1ps
module irq_cmd_chk (
  input logic        clk,
  input logic        hardRstN,
  input logic        softRst,
  input logic        cfgLoadStart,
  input logic        cfgLoadFail,
  input logic        wrEn,
  input logic        legacyWrEn,
  input logic        globalIrqEn,
  input logic [31:0] rdData,
  input logic [15:0] legacyRdData,
  input logic        irqSummary,
  input logic        irqPinN
);
  // R2
  value_bits_zero_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    {rdData[31], rdData[23], rdData[15], rdData[7]} == 4'b0000);

  // R4
  pin_low_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (irqSummary && globalIrqEn) |=> !irqPinN);

  // R4
  pin_high_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    !(irqSummary && globalIrqEn) |=> irqPinN);

  // R6
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgLoadStart || cfgLoadFail) |=> (rdData == 32'h0));

  // R7
  soft_set_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (softRst && !cfgLoadStart && !cfgLoadFail) |=> (rdData[1:0] == 2'b11));

  // R8
  alias_view_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    {legacyRdData[8], legacyRdData[4], legacyRdData[2], legacyRdData[0]} == rdData[19:16]);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    !(wrEn || legacyWrEn || softRst || cfgLoadStart || cfgLoadFail) |=> $stable(rdData));
endmodule

bind irq_enable_cmd_reg irq_cmd_chk u_chk (
  .clk          (clk),
  .hardRstN     (hardRstN),
  .softRst      (softRst),
  .cfgLoadStart (cfgLoadStart),
  .cfgLoadFail  (cfgLoadFail),
  .wrEn         (wrEn),
  .legacyWrEn   (legacyWrEn),
  .globalIrqEn  (globalIrqEn),
  .rdData       (rdData),
  .legacyRdData (legacyRdData),
  .irqSummary   (irqSummary),
  .irqPinN      (irqPinN)
);

// File: tb/irq_enable_cmd_reg_tb.sv
`timescale 1ns/1ps
module irq_enable_cmd_reg_tb;
  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cfgLoadStart = 1'b0;
  logic        cfgLoadFail = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        legacyWrEn = 1'b0;
  logic [15:0] legacyWrData = '0;
  logic [31:0] irqStatus = '0;
  logic        globalIrqEn = 1'b0;
  logic [31:0] rdData;
  logic [15:0] legacyRdData;
  logic        irqSummary;
  logic        irqPinN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_enable_cmd_reg u_dut (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst),
    .cfgLoadStart(cfgLoadStart), .cfgLoadFail(cfgLoadFail),
    .wrEn(wrEn), .wrData(wrData), .legacyWrEn(legacyWrEn),
    .legacyWrData(legacyWrData), .irqStatus(irqStatus),
    .globalIrqEn(globalIrqEn), .rdData(rdData),
    .legacyRdData(legacyRdData), .irqSummary(irqSummary),
    .irqPinN(irqPinN)
  );

  // Each entry: {command word, expected rdData}, applied in order from zero.
  localparam logic [63:0] VEC [6] = '{
    {32'h8383_8383, 32'h0303_0303},
    {32'h0001_0000, 32'h0302_0303},
    {32'hFF00_0000, 32'h7F02_0303},
    {32'h7F00_80FF, 32'h0002_037F},
    {32'h0000_0A05, 32'h0002_017A},
    {32'h9400_0000, 32'h1402_017A}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Advance one edge, sample just after it, then drop all strobes.
  task automatic tick();
    @(posedge clk);
    #1;
    wrEn = 1'b0; legacyWrEn = 1'b0; softRst = 1'b0;
    cfgLoadStart = 1'b0; cfgLoadFail = 1'b0;
  endtask

  task automatic cmdWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R5 reset state
    check("R5 reset rd", rdData, 32'h0);
    check("R5 reset pin", {31'b0, irqPinN}, 32'h1);
    hardRstN = 1'b1;
    tick();

    // R1 / R2: table walk
    for (int i = 0; i < 6; i++) begin
      cmdWrite(VEC[i][63:32]);
      check("R1 R2 table", rdData, VEC[i][31:0]);
    end

    // R10 hold over idle cycles
    tick(); tick();
    check("R10 hold", rdData, 32'h1402_017A);

    // R3: byte0 enables are 0x7A
    irqStatus = 32'h0000_0080; #1;
    check("R3 value position ignored", {31'b0, irqSummary}, 32'h0);
    irqStatus = 32'h0000_0001; #1;
    check("R3 disabled bit", {31'b0, irqSummary}, 32'h0);
    irqStatus = 32'h0000_0002; #1;
    check("R3 enabled bit", {31'b0, irqSummary}, 32'h1);

    // R4: pin needs the global enable and lags by one edge
    globalIrqEn = 1'b0; tick();
    check("R4 pin gated", {31'b0, irqPinN}, 32'h1);
    globalIrqEn = 1'b1; #1;
    check("R4 pin before edge", {31'b0, irqPinN}, 32'h1);
    tick();
    check("R4 pin asserted", {31'b0, irqPinN}, 32'h0);
    irqStatus = 32'h0; tick();
    check("R4 pin released", {31'b0, irqPinN}, 32'h1);
    globalIrqEn = 1'b0;

    // R8: legacy view, byte2 enables are 0x02
    check("R8 legacy read", {16'b0, legacyRdData}, 32'h0000_0004);
    legacyWrEn = 1'b1; legacyWrData = 16'h0103; tick();
    check("R8 legacy write rd", rdData, 32'h1409_017A);
    check("R8 legacy write view", {16'b0, legacyRdData}, 32'h0000_0101);

    // R9: collision of command and legacy writes
    wrEn = 1'b1; wrData = 32'h008F_0084;
    legacyWrEn = 1'b1; legacyWrData = 16'h0000;
    tick();
    check("R9 legacy wins", rdData, 32'h1400_017E);

    // R7: soft reset drops a write in the same cycle
    softRst = 1'b1; wrEn = 1'b1; wrData = 32'h0000_7F7F;
    legacyWrEn = 1'b1; legacyWrData = 16'h0115;
    tick();
    check("R7 soft reset", rdData, 32'h1400_017F);

    // R6: clear beats write, then load failure clears
    cfgLoadStart = 1'b1; wrEn = 1'b1; wrData = 32'hFFFF_FFFF; tick();
    check("R6 load start clear", rdData, 32'h0);
    cmdWrite(32'h8383_8383);
    cfgLoadFail = 1'b1; tick();
    check("R6 load fail clear", rdData, 32'h0);
    cfgLoadStart = 1'b1; softRst = 1'b1; tick();
    check("R6 clear beats soft reset", rdData, 32'h0);

    // R5: asynchronous hard reset mid-cycle
    cmdWrite(32'h8383_8383);
    irqStatus = 32'hFFFF_FFFF; globalIrqEn = 1'b1;
    tick();
    check("R5 pin low before reset", {31'b0, irqPinN}, 32'h0);
    #1 hardRstN = 1'b0;
    #0.5;
    check("R5 async clear", rdData, 32'h0);
    check("R5 async pin", {31'b0, irqPinN}, 32'h1);
    check("R5 summary after reset", {31'b0, irqSummary}, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule